// File: doc/BRIEF.md
# NMI Aggregator with Service Watchdog

This block gathers six hardware error sources into one non-maskable interrupt for a CPU subsystem. Each source event is held in its own flag bit. A summary flag records that an NMI was raised. When a new NMI appears, the block sends a single-cycle pulse to the CPU. Software reads the flags, clears them through a write-one-to-clear port, and can force any source flag to test the handler path. Five sources are always live. The inter-core bus error source is off after reset and is switched on by a sticky configuration bit.

While any flag stays set, a 16-bit watchdog counts subsystem clocks. If software does not clear every flag before the count reaches the programmed period, the block emits a one-cycle device reset request and latches a sticky cause bit. Source events arrive as synchronous single-clock pulses.

Top module: `nmi_wd_ctrl`

## Requirements
- R1: Each source event sets its own flag one clock later. Flag layout: bit 0 is the summary flag, and bits 1 to 6 are the sources in this order: external pin, clock failure, coprocessor interrupt error, coprocessor watchdog reset, inter-core bus error, built-in self-test error. `src_evt_i` bit i maps to flag bit i+1.
- R2: Five sources are always enabled and cannot be masked. The bus error source (source index 4) is gated by the enable bit.
- R3: A configuration write with data bit 9 set turns the bus error enable on. A later write with bit 9 at 0 leaves the enable set. Only `rst_ni` clears it.
- R4: While the bus error source is disabled, a bus error event or a force of that source changes no flag and raises no pulse.
- R5: A clear write with a 1 in a flag's bit position clears that flag. If a source event arrives in the same cycle as the clear of its flag, the flag stays set.
- R6: A force write sets the flags for the sources whose bits are 1 in `frc_data_i` (bit i = source i). A forced source raises the summary flag and the pulse exactly as a real event would.
- R7: Any accepted event or force sets the summary flag. Clear bit 0 clears the summary flag, unless an event arrives in the same cycle.
- R8: `nmi_pulse_o` is high for one cycle, one clock after an accepted event or force, when either a source flag goes from clear to set or the summary flag was clear. A repeated event on flags that are already set gives no pulse.
- R9: While any flag is set, `wd_cnt_o` rises by one per clock, starting from 0 on the clock after the first flag sets.
- R10: When the count is at or above the period, `rst_req_o` pulses high for one cycle and `wd_cause_o` becomes set and stays set. The count then holds until the flags are cleared.
- R11: One clock after all flags read zero, the count returns to 0.
- R12: After reset, flags, count, pulse, request, cause and enable are all 0, and the period is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Subsystem clock |
| rst_ni | input | 1 | Active-low asynchronous subsystem reset |
| src_evt_i | input | 6 | Source event pulses, bit i = source i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data, bit 9 = bus error enable |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | 7 | Write-one-to-clear mask in flag layout |
| frc_we_i | input | 1 | Force write strobe |
| frc_data_i | input | 6 | Force mask, bit i = source i |
| prd_we_i | input | 1 | Watchdog period write strobe |
| prd_data_i | input | 16 | Watchdog period value |
| flag_o | output | 7 | Flag register, bit 0 summary |
| bus_err_en_o | output | 1 | Bus error source enable |
| wd_prd_o | output | 16 | Current watchdog period |
| wd_cnt_o | output | 16 | Watchdog count |
| nmi_pulse_o | output | 1 | One-cycle NMI pulse to CPU |
| rst_req_o | output | 1 | One-cycle device reset request |
| wd_cause_o | output | 1 | Sticky watchdog reset cause |

## Verification
Two situations are hard to reach from the ports: watchdog expiry and a clear that lands in the same cycle as a new event. At the default period, expiry would take 65,535 cycles. The stimulus therefore writes a short period first. It then holds one flag unserviced and samples the count at known offsets from the first flag edge, which shows the exact cycle of the reset pulse and the hold after it. The collision case is a table entry that drives a clear mask and a source event together. The table also presses the disabled bus error source through both its event input and the force port before the enable is set.

// File: rtl/nmi_wd_pkg.sv
package nmi_wd_pkg;
  localparam int NUM_SRC  = 6;
  localparam int FLAG_W   = NUM_SRC + 1;
  localparam int CNT_W    = 16;
  localparam int CFG_W    = 16;
  localparam int EN_BIT   = 9;
  localparam int SRC_PIN  = 0;
  localparam int SRC_CLK  = 1;
  localparam int SRC_CIRQ = 2;
  localparam int SRC_CWD  = 3;
  localparam int SRC_BUS  = 4;
  localparam int SRC_BIST = 5;
endpackage

// File: rtl/nmi_cfg_regs.sv
module nmi_cfg_regs #(
  parameter int CFG_W   = 16,
  parameter int EN_BIT  = 9,
  parameter int CNT_W   = 16,
  parameter logic [CNT_W-1:0] PRD_RST = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             prd_we_i,
  input  logic [CNT_W-1:0] prd_data_i,
  output logic             bus_en_o,
  output logic [CNT_W-1:0] prd_o
);
  logic en_q;
  logic [CNT_W-1:0] prd_q;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata_i[CFG_W-1:EN_BIT+1], cfg_wdata_i[EN_BIT-1:0]};

  // enable is set-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      prd_q <= PRD_RST;
    end else begin
      en_q <= en_q | (cfg_we_i & cfg_wdata_i[EN_BIT]);
      if (prd_we_i) prd_q <= prd_data_i;
    end
  end

  assign bus_en_o = en_q;
  assign prd_o    = prd_q;
endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int NUM_SRC   = 6,
  parameter int GATED_IDX = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               gate_en_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC:0]   clr_i,
  input  logic               frc_we_i,
  input  logic [NUM_SRC-1:0] frc_i,
  output logic [NUM_SRC:0]   flag_o,
  output logic               pulse_o
);
  logic [NUM_SRC-1:0] en_mask, eff, clr_src, src_q;
  logic sum_q, pulse_q, clr_sum, any_eff;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
    if (i == GATED_IDX) begin : g_gated
      assign en_mask[i] = gate_en_i;
    end else begin : g_live
      assign en_mask[i] = 1'b1;
    end
  end

  always_comb begin
    eff     = (evt_i | (frc_we_i ? frc_i : '0)) & en_mask;
    any_eff = |eff;
    clr_src = clr_we_i ? clr_i[NUM_SRC:1] : '0;
    clr_sum = clr_we_i & clr_i[0];
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      sum_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      src_q   <= (src_q & ~clr_src) | eff;
      sum_q   <= (sum_q & ~clr_sum) | any_eff;
      pulse_q <= (|(eff & ~src_q)) | (any_eff & ~sum_q);
    end
  end

  assign flag_o  = {src_q, sum_q};
  assign pulse_o = pulse_q;
endmodule

// File: rtl/nmi_wdog.sv
module nmi_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o,
  output logic             cause_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic req_q, hit_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      req_q   <= 1'b0;
      hit_q   <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!active_i) begin
        cnt_q <= '0;
        hit_q <= 1'b0;
      end else if (cnt_q >= prd_i) begin
        // fire once per episode, then hold
        if (!hit_q) begin
          req_q   <= 1'b1;
          hit_q   <= 1'b1;
          cause_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = req_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/nmi_wd_ctrl.sv
module nmi_wd_ctrl
  import nmi_wd_pkg::*;
#(
  parameter logic [CNT_W-1:0] PRD_RST = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               clr_we_i,
  input  logic [FLAG_W-1:0]  clr_data_i,
  input  logic               frc_we_i,
  input  logic [NUM_SRC-1:0] frc_data_i,
  input  logic               prd_we_i,
  input  logic [CNT_W-1:0]   prd_data_i,
  output logic [FLAG_W-1:0]  flag_o,
  output logic               bus_err_en_o,
  output logic [CNT_W-1:0]   wd_prd_o,
  output logic [CNT_W-1:0]   wd_cnt_o,
  output logic               nmi_pulse_o,
  output logic               rst_req_o,
  output logic               wd_cause_o
);
  logic bus_en;
  logic [CNT_W-1:0] prd;
  logic [FLAG_W-1:0] flags;

  nmi_cfg_regs #(.CFG_W(CFG_W), .EN_BIT(EN_BIT), .CNT_W(CNT_W), .PRD_RST(PRD_RST)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i,
    .prd_we_i, .prd_data_i, .bus_en_o(bus_en), .prd_o(prd)
  );

  nmi_flag_bank #(.NUM_SRC(NUM_SRC), .GATED_IDX(SRC_BUS)) u_flags (
    .clk_i, .rst_ni, .evt_i(src_evt_i), .gate_en_i(bus_en),
    .clr_we_i, .clr_i(clr_data_i), .frc_we_i, .frc_i(frc_data_i),
    .flag_o(flags), .pulse_o(nmi_pulse_o)
  );

  nmi_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk_i, .rst_ni, .active_i(|flags), .prd_i(prd),
    .cnt_o(wd_cnt_o), .rst_req_o, .cause_o(wd_cause_o)
  );

  assign flag_o       = flags;
  assign bus_err_en_o = bus_en;
  assign wd_prd_o     = prd;
endmodule

// File: rtl/nmi_wd_chk.sv
module nmi_wd_chk
  import nmi_wd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_evt_i,
  input logic [FLAG_W-1:0]  flag_o,
  input logic               bus_err_en_o,
  input logic [CNT_W-1:0]   wd_cnt_o,
  input logic               nmi_pulse_o,
  input logic               rst_req_o,
  input logic               wd_cause_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i != SRC_BUS) begin : g_live
      // R1 R2
      src_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_evt_i[i] |=> (flag_o[i+1] && flag_o[0]));
    end
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_en_o |=> bus_err_en_o);

  // R8
  pulse_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pulse_o |-> flag_o[0]);

  // R10
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  // R10
  cause_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cause_o |=> wd_cause_o);

  // R10
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> wd_cause_o);

  // R11
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == '0) |=> (wd_cnt_o == '0));
endmodule

bind nmi_wd_ctrl nmi_wd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_evt_i(src_evt_i), .flag_o(flag_o),
  .bus_err_en_o(bus_err_en_o), .wd_cnt_o(wd_cnt_o), .nmi_pulse_o(nmi_pulse_o),
  .rst_req_o(rst_req_o), .wd_cause_o(wd_cause_o)
);

// File: tb/tb_nmi_wd_ctrl.sv
module tb_nmi_wd_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 13;
  localparam int  VW = 27;
  // {src[6], clr[7], frc[6], exp_flag[7], exp_pulse}
  localparam logic [VW-1:0] VEC [NV] = '{
    {6'b000001, 7'b0000000, 6'b000000, 7'b0000011, 1'b1}, // R1 R8 new
    {6'b000000, 7'b0000000, 6'b000000, 7'b0000011, 1'b0}, // R1 held
    {6'b000001, 7'b0000000, 6'b000000, 7'b0000011, 1'b0}, // R8 repeat
    {6'b000000, 7'b0000011, 6'b000000, 7'b0000000, 1'b0}, // R5 R7
    {6'b100010, 7'b0000000, 6'b000000, 7'b1000101, 1'b1}, // R1 R2
    {6'b000000, 7'b0000001, 6'b000000, 7'b1000100, 1'b0}, // R7 summary clear
    {6'b000100, 7'b0000000, 6'b000000, 7'b1001101, 1'b1}, // R8 summary clear
    {6'b010000, 7'b0000000, 6'b000000, 7'b1001101, 1'b0}, // R4 event
    {6'b000000, 7'b0000000, 6'b010000, 7'b1001101, 1'b0}, // R4 force
    {6'b000100, 7'b1001101, 6'b000000, 7'b0001001, 1'b0}, // R5 collision
    {6'b000000, 7'b1111111, 6'b000000, 7'b0000000, 1'b0}, // R5
    {6'b000000, 7'b0000000, 6'b001000, 7'b0010001, 1'b1}, // R6 force
    {6'b000000, 7'b1111111, 6'b000000, 7'b0000000, 1'b0}  // R5
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] src_evt_i = '0, frc_data_i = '0;
  logic cfg_we_i = 0, clr_we_i = 0, frc_we_i = 0, prd_we_i = 0;
  logic [15:0] cfg_wdata_i = '0, prd_data_i = '0;
  logic [6:0] clr_data_i = '0;
  logic [6:0] flag_o;
  logic bus_err_en_o, nmi_pulse_o, rst_req_o, wd_cause_o;
  logic [15:0] wd_prd_o, wd_cnt_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nmi_wd_ctrl dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    src_evt_i = '0; cfg_we_i = 0; clr_we_i = 0; frc_we_i = 0; prd_we_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk_i); rst_ni = 1;
    chk("R12 flags", flag_o, 0);
    chk("R12 cnt", wd_cnt_o, 0);
    chk("R12 prd", wd_prd_o, 16'hFFFF);
    chk("R12 en", bus_err_en_o, 0);
    chk("R12 cause", wd_cause_o, 0);
    chk("R12 pulse/req", {nmi_pulse_o, rst_req_o}, 0);

    for (int v = 0; v < NV; v++) begin
      src_evt_i  = VEC[v][26:21];
      clr_data_i = VEC[v][20:14]; clr_we_i = |VEC[v][20:14];
      frc_data_i = VEC[v][13:8];  frc_we_i = |VEC[v][13:8];
      step();
      chk($sformatf("R1/R4-R8 vec%0d flag", v), flag_o, VEC[v][7:1]);
      chk($sformatf("R8 vec%0d pulse", v), nmi_pulse_o, VEC[v][0]);
    end
    step();
    chk("R11 cnt idle", wd_cnt_o, 0);

    cfg_we_i = 1; cfg_wdata_i = 16'h0200; step();
    chk("R3 en set", bus_err_en_o, 1);
    cfg_we_i = 1; cfg_wdata_i = 16'h0000; step();
    chk("R3 en sticky", bus_err_en_o, 1);
    src_evt_i = 6'b010000; step();
    chk("R2 bus flag", flag_o, 7'b0100001);
    chk("R8 bus pulse", nmi_pulse_o, 1);
    clr_we_i = 1; clr_data_i = '1; step(); step();

    prd_we_i = 1; prd_data_i = 16'd5; step();
    chk("R10 prd", wd_prd_o, 5);
    src_evt_i = 6'b000001; step();
    chk("R9 cnt start", wd_cnt_o, 0);
    for (int k = 0; k < 4; k++) step();
    chk("R9 cnt4", wd_cnt_o, 4);
    step();
    chk("R9 cnt5", wd_cnt_o, 5);
    chk("R10 no req yet", rst_req_o, 0);
    step();
    chk("R10 req", rst_req_o, 1);
    chk("R10 cause", wd_cause_o, 1);
    step();
    chk("R10 req single", rst_req_o, 0);
    chk("R10 hold", wd_cnt_o, 5);
    clr_we_i = 1; clr_data_i = '1; step();
    chk("R11 flags clear", flag_o, 0);
    step();
    chk("R11 cnt zero", wd_cnt_o, 0);
    chk("R10 cause kept", wd_cause_o, 1);

    rst_ni = 0; #(CLK_PERIOD); rst_ni = 1; @(negedge clk_i);
    chk("R3 R12 en reset", bus_err_en_o, 0);
    chk("R12 cause reset", wd_cause_o, 0);
    chk("R12 prd reset", wd_prd_o, 16'hFFFF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule